// File: doc/BRIEF.md
# SPI Master Chip-Select Hold Controller

This block owns the active-low chip-select pin of an SPI master. Software writes a 32-bit transmit word through a byte-enabled port. Bits 15:0 carry the data to send. Bit 28 is a hold flag. A write that enables either data byte starts a transfer. A write that enables only the upper byte changes the stored hold flag and starts nothing.

When a transfer finishes with the hold flag set, chip select stays low, so the next word goes out without a gap. When it finishes with the flag clear, chip select goes high after a short trailing delay. The separate shift engine receives a one-cycle start pulse with the data word and returns a one-cycle done pulse.

Before the first start, chip select leads the start pulse by a programmable number of clock cycles. The same lead applies after the pin has been released. When the pin is already held low, a new word starts at once, so the pin never rises between held words. The hold behaviour applies only while the master-mode input is high.

Top module: `spi_cs_hold_ctrl`

## Requirements
- R1: During and after synchronous reset, `cs_n` is 1, `xfer_start` is 0, and the stored hold flag is 0. A halfword data write that follows reset therefore releases chip select after its transfer.
- R2: When the controller is idle, a write with `wr_be[0]` or `wr_be[1]` set pulls `cs_n` low in the following cycle. `xfer_start` then pulses after `LEAD_CYC` cycles of `cs_n` low. `xfer_data` carries bits 15:0, merged byte lane by byte lane: `wr_be[0]` updates bits 7:0 and `wr_be[1]` updates bits 15:8.
- R3: A transfer launched with an effective hold value of 1 leaves `cs_n` low indefinitely after `xfer_done`.
- R4: A transfer launched with an effective hold value of 0 keeps `cs_n` low for `TRAIL_CYC` cycles after the cycle in which `xfer_done` is sampled, then drives `cs_n` high.
- R5: While chip select is held, a data write raises `xfer_start` in the next cycle, and `cs_n` stays low throughout.
- R6: While chip select is held, a write that enables `wr_be[3]` and neither data byte, with bit 28 = 0, drives `cs_n` high in the next cycle and produces no `xfer_start`.
- R7: A hold-only write stores bit 28 at any time without starting a transfer. A later data write that does not enable `wr_be[3]` uses the stored value.
- R8: A data write that also enables `wr_be[3]` applies its own bit 28 to the transfer it starts, and stores that value.
- R9: While `master_en` is 0, `cs_n` stays 1 and transfers are launched with an effective hold value of 0. Transfers are still started.
- R10: A data write that arrives while a transfer is in lead, launch, shift or trail is ignored. Its data, its hold bit and any extra start are all discarded.
- R11: `xfer_start` is never high for two consecutive cycles. After a start, `xfer_done` pulses are ignored except the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | 1 selects master mode, which enables chip select and hold |
| wr_en | input | 1 | Write strobe for the transmit word |
| wr_be | input | 4 | Byte enables of the write |
| wr_data | input | 32 | Write data: bits 15:0 data, bit 28 hold |
| xfer_start | output | 1 | One-cycle start pulse to the shift engine |
| xfer_data | output | 16 | Word to shift, valid with `xfer_start` |
| xfer_done | input | 1 | One-cycle completion pulse from the shift engine |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench runs a behavioural reference model and compares every cycle. Stimulus covers the following cases:
- Isolated word writes with hold clear separate the lead and trail timing from the held path.
- Full-word writes with hold set, followed by halfword writes, show whether the stored flag or the written flag governs each transfer.
- Upper-byte-only writes, both while held and while idle, separate releasing chip select from starting a transfer.
- Data and hold writes issued mid-transfer, and a pass with master mode off, expose dropped-write and mode-gating faults.

// File: rtl/spi_csh_pkg.sv
package spi_csh_pkg;

    localparam int WORD_W   = 32;
    localparam int DATA_W   = 16;
    localparam int BE_W     = WORD_W / 8;
    localparam int DATA_BYT = DATA_W / 8;
    localparam int HOLD_POS = 28;
    localparam int HOLD_BYT = HOLD_POS / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LAUNCH,
        ST_SHIFT,
        ST_TRAIL,
        ST_PARK
    } csh_state_e;

    typedef struct packed {
        logic data_hit;
        logic hold_hit;
        logic hold_only;
        logic hold_val;
    } wr_req_t;

    function automatic wr_req_t decode_wr(input logic [BE_W-1:0] be,
                                          input logic [WORD_W-1:0] d);
        wr_req_t r;
        r.data_hit  = |be[DATA_BYT-1:0];
        r.hold_hit  = be[HOLD_BYT];
        r.hold_only = be[HOLD_BYT] & ~(|be[DATA_BYT-1:0]);
        r.hold_val  = d[HOLD_POS];
        return r;
    endfunction

endpackage

// File: rtl/csh_regs.sv
module csh_regs
    import spi_csh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              master_en,
    input  logic              wr_en,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              accept,
    output logic [DATA_W-1:0] data_q,
    output logic              data_go,
    output logic              launch_hold,
    output logic              hold_drop
);

    wr_req_t req;
    logic    hold_q;

    always_comb begin
        req         = decode_wr(wr_be, wr_data);
        data_go     = wr_en & req.data_hit & accept;
        hold_drop   = wr_en & req.hold_only & ~req.hold_val;
        launch_hold = master_en & (req.hold_hit ? req.hold_val : hold_q);
    end

    for (genvar b = 0; b < DATA_BYT; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                data_q[b*8 +: 8] <= '0;
            else if (data_go && wr_be[b])
                data_q[b*8 +: 8] <= wr_data[b*8 +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= 1'b0;
        else if (data_go && req.hold_hit)
            hold_q <= req.hold_val;
        else if (wr_en && req.hold_only)
            hold_q <= req.hold_val;
    end

    // R10
    drop_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && req.data_hit && !accept) |=> $stable(data_q));

    // R7
    hold_only_no_go_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && req.hold_only) |-> !data_go);

endmodule

// File: rtl/csh_seq.sv
module csh_seq
    import spi_csh_pkg::*;
#(
    parameter int LEAD_CYC  = 3,
    parameter int TRAIL_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic data_go,
    input  logic launch_hold,
    input  logic hold_drop,
    input  logic xfer_done,
    output logic accept,
    output logic start,
    output logic cs_active
);

    localparam int MAX_CYC = (LEAD_CYC > TRAIL_CYC) ? LEAD_CYC : TRAIL_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] LEAD_LAST  = CNT_W'(LEAD_CYC - 1);
    localparam logic [CNT_W-1:0] TRAIL_LAST = CNT_W'(TRAIL_CYC - 1);

    csh_state_e       st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             xfer_hold;

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        unique case (st)
            ST_IDLE: begin
                cnt_nx = '0;
                if (data_go) st_nx = ST_LEAD;
            end
            ST_LEAD: begin
                if (cnt == LEAD_LAST) begin
                    st_nx  = ST_LAUNCH;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_LAUNCH: st_nx = ST_SHIFT;
            ST_SHIFT: begin
                cnt_nx = '0;
                if (xfer_done) st_nx = xfer_hold ? ST_PARK : ST_TRAIL;
            end
            ST_TRAIL: begin
                if (cnt == TRAIL_LAST) begin
                    st_nx  = ST_IDLE;
                    cnt_nx = '0;
                end else begin
                    cnt_nx = cnt + 1'b1;
                end
            end
            ST_PARK: begin
                if (data_go)        st_nx = ST_LAUNCH;
                else if (hold_drop) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            xfer_hold <= 1'b0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
            if (data_go) xfer_hold <= launch_hold;
        end
    end

    assign accept    = (st == ST_IDLE) || (st == ST_PARK);
    assign start     = (st == ST_LAUNCH);
    assign cs_active = (st != ST_IDLE);

    // R11
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> !start);

    // R5
    park_no_glitch_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PARK && data_go) |=> (cs_active && start));

    // R6
    park_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PARK && hold_drop && !data_go) |=> (!cs_active && !start));

    // R3
    held_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SHIFT && xfer_done && xfer_hold) |=> (cs_active && !start));

    // R4
    trail_keeps_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SHIFT && xfer_done && !xfer_hold) |=> cs_active);

    // R2
    lead_before_start_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && data_go) |=> (cs_active && !start));

endmodule

// File: rtl/spi_cs_hold_ctrl.sv
module spi_cs_hold_ctrl
    import spi_csh_pkg::*;
#(
    parameter int LEAD_CYC  = 3,
    parameter int TRAIL_CYC = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        master_en,
    input  logic        wr_en,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    output logic        xfer_start,
    output logic [15:0] xfer_data,
    input  logic        xfer_done,
    output logic        cs_n
);

    logic accept, data_go, launch_hold, hold_drop, cs_active;

    csh_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .master_en   (master_en),
        .wr_en       (wr_en),
        .wr_be       (wr_be),
        .wr_data     (wr_data),
        .accept      (accept),
        .data_q      (xfer_data),
        .data_go     (data_go),
        .launch_hold (launch_hold),
        .hold_drop   (hold_drop)
    );

    csh_seq #(
        .LEAD_CYC  (LEAD_CYC),
        .TRAIL_CYC (TRAIL_CYC)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .data_go     (data_go),
        .launch_hold (launch_hold),
        .hold_drop   (hold_drop),
        .xfer_done   (xfer_done),
        .accept      (accept),
        .start       (xfer_start),
        .cs_active   (cs_active)
    );

    assign cs_n = ~(master_en & cs_active);

    // R9
    slave_cs_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!master_en) |-> cs_n);

endmodule

// File: tb/sim_spi_cs_hold_ctrl.sv
module sim_spi_cs_hold_ctrl;

    localparam int LEAD  = 3;
    localparam int TRAIL = 2;
    localparam int XLEN  = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        master_en = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic        xfer_done = 1'b0;
    logic        xfer_start;
    logic [15:0] xfer_data;
    logic        cs_n;

    always #5 clk = ~clk;

    spi_cs_hold_ctrl #(.LEAD_CYC(LEAD), .TRAIL_CYC(TRAIL)) u0 (
        .clk(clk), .rst(rst), .master_en(master_en), .wr_en(wr_en),
        .wr_be(wr_be), .wr_data(wr_data), .xfer_start(xfer_start),
        .xfer_data(xfer_data), .xfer_done(xfer_done), .cs_n(cs_n)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    int    eng_cnt = 0;
    int    cycles = 0;
    string cur_req = "R1";

    // reference model: phase 0 idle, 1 lead, 2 launch, 3 shift, 4 trail, 5 parked
    int          m_ph = 0;
    int          m_cnt = 0;
    bit          m_hold = 0;
    bit          m_xh = 0;
    logic [15:0] m_data = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_hold = 0; m_xh = 0; m_data = '0;
        end else begin
            bit dw, ho, acc, use_h;
            dw    = wr_en && (wr_be[0] || wr_be[1]);
            ho    = wr_en && wr_be[3] && !wr_be[0] && !wr_be[1];
            acc   = (m_ph == 0) || (m_ph == 5);
            use_h = master_en && (wr_be[3] ? wr_data[28] : m_hold);
            case (m_ph)
                0: if (dw) begin m_ph = 1; m_cnt = 0; end
                1: if (m_cnt == LEAD - 1) m_ph = 2; else m_cnt++;
                2: m_ph = 3;
                3: if (xfer_done) begin
                       if (m_xh) m_ph = 5; else begin m_ph = 4; m_cnt = 0; end
                   end
                4: if (m_cnt == TRAIL - 1) m_ph = 0; else m_cnt++;
                5: if (dw) m_ph = 2; else if (ho && !wr_data[28]) m_ph = 0;
                default: m_ph = 0;
            endcase
            if (dw && acc) begin
                m_xh = use_h;
                if (wr_be[0]) m_data[7:0]  = wr_data[7:0];
                if (wr_be[1]) m_data[15:8] = wr_data[15:8];
                if (wr_be[3]) m_hold = wr_data[28];
            end else if (ho) begin
                m_hold = wr_data[28];
            end
        end
    end

    task automatic check_now();
        bit          e_cs;
        bit          e_st;
        e_cs = !(master_en && m_ph != 0);
        e_st = (m_ph == 2);
        n_vec++;
        if (cs_n !== e_cs || xfer_start !== e_st ||
            (e_st && xfer_data !== m_data)) begin
            n_bad++;
            $display("FAIL %s cycle %0d: cs_n=%b start=%b data=%h expected cs_n=%b start=%b data=%h",
                     cur_req, cycles, cs_n, xfer_start, xfer_data, e_cs, e_st, m_data);
        end
    endtask

    // one cycle: compare at the falling edge, run the engine, then drive inputs
    task automatic cyc(input bit we, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cycles++;
        if (!rst) check_now();
        xfer_done = 1'b0;
        if (eng_cnt > 0) begin
            eng_cnt--;
            if (eng_cnt == 0) xfer_done = 1'b1;
        end
        if (xfer_start === 1'b1) eng_cnt = XLEN;
        wr_en   = we;
        wr_be   = be;
        wr_data = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 4'h0, 32'h0);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        cur_req = "R1";
        idle(3);
        @(negedge clk); rst = 1'b0;
        idle(3);
        // R2 R4 halfword write, stored hold 0 after reset
        cur_req = "R2";
        cyc(1'b1, 4'b0011, 32'h0000_A5C3);
        idle(6);
        cur_req = "R4";
        idle(12);
        // R8 R3 full word with hold=1
        cur_req = "R8";
        cyc(1'b1, 4'b1111, 32'h1000_5A17);
        cur_req = "R3";
        idle(14);
        // R5 back-to-back while held, stored hold still 1
        cur_req = "R5";
        cyc(1'b1, 4'b0011, 32'h0000_1234);
        idle(12);
        // R6 hold-only clear while parked
        cur_req = "R6";
        cyc(1'b1, 4'b1000, 32'h0000_0000);
        idle(5);
        // R7 hold-only set while idle, then halfword write uses it
        cur_req = "R7";
        cyc(1'b1, 4'b1000, 32'h1000_0000);
        idle(4);
        cyc(1'b1, 4'b0011, 32'h0000_BEEF);
        idle(14);
        // R8 full word clearing hold from parked state
        cur_req = "R8";
        cyc(1'b1, 4'b1111, 32'h0000_C0DE);
        idle(16);
        // R2 single byte lane merge
        cur_req = "R2";
        cyc(1'b1, 4'b0001, 32'hFFFF_FF44);
        idle(16);
        // R10 writes during a transfer are dropped, hold-only still stored
        cur_req = "R10";
        cyc(1'b1, 4'b0011, 32'h0000_1111);
        idle(2);
        cyc(1'b1, 4'b1011, 32'h1000_2222);
        idle(3);
        cyc(1'b1, 4'b0011, 32'h0000_3333);
        cur_req = "R7";
        cyc(1'b1, 4'b1000, 32'h1000_0000);
        idle(14);
        cur_req = "R10";
        cyc(1'b1, 4'b0010, 32'h0000_4400);
        idle(12);
        cur_req = "R6";
        cyc(1'b1, 4'b1000, 32'h0000_0000);
        idle(4);
        // R11 stray done pulses outside a transfer
        cur_req = "R11";
        @(negedge clk); xfer_done = 1'b1;
        idle(4);
        // R9 slave mode: cs stays high, hold ignored
        cur_req = "R9";
        @(negedge clk); master_en = 1'b0;
        cyc(1'b1, 4'b1111, 32'h1000_7777);
        idle(16);
        cyc(1'b1, 4'b0011, 32'h0000_8888);
        idle(16);
        @(negedge clk); master_en = 1'b1;
        idle(3);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule